// File: doc/BRIEF.md
# Edge-Started Single-Run Timer

This block is a 16-bit up-counter that stays quiet until it sees an edge on an external trigger input. The edge polarity is set by software. After the edge, the counter advances once per prescaled timer tick, from a loaded start value toward a programmable terminal value. When it gets there, three things happen. The timer output leaves its resting level for one timer-clock period. An interrupt request pulses for one clock. The counter rearms at one. The block then waits for the next trigger. Each trigger therefore produces exactly one timeout, and the timeout is (terminal − start) × 2^N timer ticks.

Software sets the block up through a small write port. It loads the start count while the timer is disabled, and it sets the terminal value, the prescaler exponent, the polarity and the enable bit. The timer clock comes in as a single-cycle enable input, `tick_en`, in the system clock domain. The trigger input may be asynchronous and is synchronised inside the block.

Top module: `trig_oneshot_timer`

## Requirements
- R1: While enabled and idle, the counter holds its value until a trigger edge of the selected polarity is detected on `trig_in`.
- R2: With polarity 0 (control bit 1 clear), a rising trigger edge starts the timer and `tmr_out` rests at 0. With polarity 1, a falling edge starts it and `tmr_out` rests at 1. An edge of the other direction does nothing.
- R3: At the terminal event, `tmr_out` takes the non-resting level for exactly one timer-clock period, that is, until the next cycle with `tick_en` high.
- R4: `irq` is high for exactly one clock cycle at each terminal event and is low at all other times.
- R5: At the terminal event the count becomes 0001h, so the next run takes (terminal − 1) ticks.
- R6: After the terminal event the timer returns to idle. Each trigger edge produces at most one terminal event.
- R7: The prescaler field N (control bits 4:2) divides the timer clock by 2^N. N = 0 means divide by 1.
- R8: With `tick_en` held high, `irq` goes high 3 + (terminal − start) × 2^N clock edges after the edge at which a changed `trig_in` is first sampled.
- R9: While the enable bit (control bit 0) is 0, trigger edges are ignored. Clearing it during a run abandons the run without an interrupt, and it clears the prescaler.
- R10: Trigger edges that arrive while a run is in progress have no effect on its timing or on the number of events.
- R11: A write to the count register takes effect only while the enable bit is 0.
- R12: Write addresses: 0 = control {bits 4:2 prescaler, bit 1 polarity, bit 0 enable}, 1 = count, 2 = terminal value. Address 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timer clock, one-cycle enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| trig_in | input | 1 | External trigger, asynchronous |
| tmr_out | output | 1 | Timer output, level set by polarity |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The hardest cases to reach are the trigger edges that land in the middle of a prescaled run. To test them, the stimulus drives `trig_in` from inside the measuring loop at chosen cycles. One edge is a falling edge and one is a rising edge, so both fall well before the terminal value is reached. The check then confirms that the interrupt still arrives on the cycle computed from the first edge, and that only one interrupt occurs. Count writes made while the timer is enabled are tested the same way: they can only be seen through the next run's length, so the bench measures that length and compares it with the length expected from the count that should have been kept.

// File: rtl/tmr_pkg.sv
// Shared types and register addresses for the edge-started single-run timer.
// Assumes a 2-bit write address and a 16-bit data path.
package tmr_pkg;
    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} tmr_state_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CNT  = 2'd1;
    localparam logic [1:0] ADDR_TERM = 2'd2;

    typedef struct packed {
        logic [2:0] psc;
        logic       pol;
        logic       en;
    } tmr_ctrl_t;
endpackage

// File: rtl/trig_sync_edge.sv
// Synchronises an asynchronous trigger through SYNC_STAGES flops and reports a
// one-cycle edge of the direction that pol selects (0 = rising, 1 = falling).
// Assumes SYNC_STAGES >= 2.
module trig_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pol,
    input  logic trig_async,
    output logic edge_det
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   cur;

    assign cur = sync_q[SYNC_STAGES-1];

    // Shift the raw input through the synchroniser and keep the previous level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], trig_async};
            last_q <= cur;
        end
    end

    // Pick the edge direction from the polarity bit.
    always_comb begin
        if (pol) edge_det = last_q & ~cur;
        else     edge_det = cur & ~last_q;
    end
endmodule

// File: rtl/tmr_prescaler.sv
// Divides the incoming timer-clock enable by 2^psc while run is high.
// Holds its counter at zero whenever run is low, so every run starts in phase.
module tmr_prescaler #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick_en,
    input  logic [PSC_W-1:0] psc,
    output logic             tick_out
);
    localparam int DIV_W = (2 ** PSC_W) - 1;

    logic [DIV_W-1:0] pcnt_q;
    logic [DIV_W-1:0] limit;

    assign limit    = DIV_W'((DIV_W+1)'(1) << psc) - DIV_W'(1);
    assign tick_out = run && tick_en && (pcnt_q == limit);

    // Count timer ticks and wrap at the selected limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pcnt_q <= '0;
        end else if (tick_en) begin
            if (pcnt_q == limit) pcnt_q <= '0;
            else                 pcnt_q <= pcnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/tmr_core.sv
// Run/idle state, the counter, the output pulse and the interrupt pulse.
// Assumes tick is already prescaled and that load is only asserted while en is low.
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             trig_edge,
    input  logic             tick,
    input  logic             tick_raw,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] term,
    output logic             running,
    output logic             pulse,
    output logic             irq,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] REARM = CNT_W'(1);

    tmr_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             pulse_q;
    logic             irq_q;
    logic             hit;

    assign hit     = (state_q == ST_RUN) && tick && ((cnt_q + REARM) == term);
    assign running = (state_q == ST_RUN);
    assign pulse   = pulse_q;
    assign irq     = irq_q;
    assign cnt     = cnt_q;

    // Step the counter, detect the terminal value and rearm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= REARM;
            pulse_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (!en) begin
                state_q <= ST_IDLE;
                pulse_q <= 1'b0;
                if (load) cnt_q <= load_val;
            end else begin
                if (pulse_q && tick_raw) pulse_q <= 1'b0;
                case (state_q)
                    ST_IDLE: if (trig_edge) state_q <= ST_RUN;
                    ST_RUN: begin
                        if (hit) begin
                            cnt_q   <= REARM;
                            state_q <= ST_IDLE;
                            pulse_q <= 1'b1;
                            irq_q   <= 1'b1;
                        end else if (tick) begin
                            cnt_q <= cnt_q + REARM;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/trig_oneshot_timer.sv
// Top level: the register write port, the trigger synchroniser, the prescaler
// and the core. The timer clock arrives as tick_en in the clk domain.
module trig_oneshot_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PSC_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             trig_in,
    output logic             tmr_out,
    output logic             irq
);
    logic             en_q;
    logic             pol_q;
    logic [PSC_W-1:0] psc_q;
    logic [CNT_W-1:0] term_q;
    logic             edge_w;
    logic             tick_w;
    logic             run_w;
    logic             pulse_w;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_w;

    assign cnt_load = wr_en && (wr_addr == ADDR_CNT) && !en_q;
    assign tmr_out  = pol_q ^ pulse_w;

    // Capture the control and terminal-value writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            pol_q  <= 1'b0;
            psc_q  <= '0;
            term_q <= '1;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTRL) begin
                en_q  <= wr_data[0];
                pol_q <= wr_data[1];
                psc_q <= wr_data[2 +: PSC_W];
            end else if (wr_addr == ADDR_TERM) begin
                term_q <= wr_data;
            end
        end
    end

    trig_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pol(pol_q), .trig_async(trig_in), .edge_det(edge_w)
    );

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .run(run_w && en_q), .tick_en(tick_en),
        .psc(psc_q), .tick_out(tick_w)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(en_q), .trig_edge(edge_w), .tick(tick_w),
        .tick_raw(tick_en), .load(cnt_load), .load_val(wr_data), .term(term_q),
        .running(run_w), .pulse(pulse_w), .irq(irq), .cnt(cnt_w)
    );
endmodule

// File: rtl/tmr_chk.sv
// Property checker for trig_oneshot_timer, attached with bind below.
module tmr_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             irq,
    input logic             running,
    input logic             pulse,
    input logic [CNT_W-1:0] cnt
);
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R4
    AST_REARM_ONE: assert property (@(posedge clk) disable iff (!rst_n) irq |-> cnt == CNT_W'(1)); // R5
    AST_IDLE_AFTER: assert property (@(posedge clk) disable iff (!rst_n) irq |-> !running); // R6
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !irq); // R9
    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !running); // R9
    AST_PULSE_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(pulse) |-> irq); // R3
endmodule

bind trig_oneshot_timer tmr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en_q), .irq(irq),
    .running(run_w), .pulse(pulse_w), .cnt(cnt_w)
);

// File: tb/trig_oneshot_timer_tb.sv
module trig_oneshot_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        trig_in = 1'b0;
    logic        tmr_out;
    logic        irq;

    int total = 0;
    int bad = 0;
    int tdiv = 1;
    bit done = 1'b0;

    always #4 clk = ~clk;

    trig_oneshot_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .trig_in(trig_in),
        .tmr_out(tmr_out), .irq(irq)
    );

    // timer clock enable: one cycle in every tdiv
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (tdiv <= 1) begin
                tick_en = 1'b1;
                ph = 0;
            end else begin
                tick_en = (ph == tdiv - 1);
                ph = (ph + 1) % tdiv;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // drive trig to lvl, then watch for limit edges; optional glitches at g1/g2
    task automatic measure(input logic lvl, input logic pol, input int limit,
                           input int g1, input int g2,
                           output int first, output int irqs, output int width);
        first = -1; irqs = 0; width = 0;
        @(negedge clk);
        trig_in = lvl;
        for (int i = 1; i <= limit; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (irq) begin
                irqs++;
                if (first < 0) first = i;
            end
            if (tmr_out != pol) width++;
            if (i == g1) trig_in = ~trig_in;
            if (i == g2) trig_in = ~trig_in;
        end
    endtask

    task automatic t_reset();
        chk(tmr_out == 1'b0, "R2 rest level after reset", tmr_out, 0);
        chk(irq == 1'b0, "R4 irq low after reset", irq, 0);
    endtask

    task automatic t_basic();
        int f, n, w;
        wr(2'd2, 16'd4);
        wr(2'd1, 16'd0);
        wr(2'd0, 16'h0001);
        idle(10);
        chk(irq == 0 && tmr_out == 0, "R1 idle without trigger", irq, 0);
        measure(1'b1, 1'b0, 30, 0, 0, f, n, w);
        chk(f == 3 + 4, "R8 R1 run length from start 0", f, 7);
        chk(n == 1, "R4 R6 one irq per trigger", n, 1);
        chk(w == 1, "R3 pulse width one tick", w, 1);
        trig_in = 1'b0;
        idle(5);
        measure(1'b1, 1'b0, 30, 0, 0, f, n, w);
        chk(f == 3 + 3, "R5 second run starts from 0001h", f, 6);
        trig_in = 1'b0;
        idle(5);
    endtask

    task automatic t_prescale();
        int f, n, w;
        wr(2'd0, 16'h0008);
        wr(2'd1, 16'd2);
        wr(2'd2, 16'd6);
        wr(2'd0, 16'h0009);
        measure(1'b1, 1'b0, 40, 0, 0, f, n, w);
        chk(f == 3 + 4 * 4, "R7 divide by 4", f, 19);
        trig_in = 1'b0;
        idle(5);
    endtask

    task automatic t_midrun_edges();
        int f, n, w;
        measure(1'b1, 1'b0, 60, 8, 14, f, n, w);
        chk(f == 3 + 5 * 4, "R10 edges during run ignored (timing)", f, 23);
        chk(n == 1, "R10 edges during run ignored (count)", n, 1);
        trig_in = 1'b0;
        idle(5);
    endtask

    task automatic t_disabled();
        int f, n, w;
        wr(2'd0, 16'h0000);
        measure(1'b1, 1'b0, 40, 0, 0, f, n, w);
        chk(n == 0, "R9 trigger ignored while disabled", n, 0);
        chk(w == 0, "R9 output quiet while disabled", w, 0);
        trig_in = 1'b0;
        idle(5);
        wr(2'd3, 16'd2);
        wr(2'd0, 16'h0001);
        measure(1'b1, 1'b0, 30, 0, 0, f, n, w);
        chk(f == 3 + 5, "R12 address 3 ignored, terminal kept", f, 8);
        trig_in = 1'b0;
        idle(5);
    endtask

    task automatic t_cnt_locked();
        int f, n, w;
        wr(2'd1, 16'd5);
        measure(1'b1, 1'b0, 30, 0, 0, f, n, w);
        chk(f == 3 + 5, "R11 count write ignored while enabled", f, 8);
        trig_in = 1'b0;
        idle(5);
    endtask

    task automatic t_abort();
        int f, n, w;
        wr(2'd2, 16'd20);
        measure(1'b1, 1'b0, 8, 0, 0, f, n, w);
        wr(2'd0, 16'h0000);
        idle(30);
        chk(irq == 0 && n == 0, "R9 disable mid-run gives no irq", n, 0);
        trig_in = 1'b0;
        wr(2'd1, 16'd1);
        wr(2'd2, 16'd4);
        wr(2'd0, 16'h0001);
        idle(5);
        measure(1'b1, 1'b0, 30, 0, 0, f, n, w);
        chk(f == 3 + 3, "R9 clean restart after abort", f, 6);
        trig_in = 1'b0;
        idle(5);
    endtask

    task automatic t_slow_tick();
        int f, n, w;
        tdiv = 3;
        measure(1'b1, 1'b0, 60, 0, 0, f, n, w);
        chk(w == 3, "R3 pulse lasts one slow timer clock", w, 3);
        chk(n == 1, "R4 one-cycle irq with slow timer clock", n, 1);
        trig_in = 1'b0;
        tdiv = 1;
        idle(5);
    endtask

    task automatic t_falling();
        int f, n, w;
        wr(2'd0, 16'h0002);
        trig_in = 1'b0;
        idle(5);
        wr(2'd0, 16'h0003);
        idle(2);
        chk(tmr_out == 1'b1, "R2 rest level 1 with polarity 1", tmr_out, 1);
        measure(1'b1, 1'b1, 30, 0, 0, f, n, w);
        chk(n == 0, "R2 rising edge ignored with polarity 1", n, 0);
        measure(1'b0, 1'b1, 30, 0, 0, f, n, w);
        chk(f == 3 + 3, "R2 falling edge starts run", f, 6);
        chk(w == 1, "R3 low-going pulse with polarity 1", w, 1);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_basic();
        t_prescale();
        t_midrun_edges();
        t_disabled();
        t_cnt_locked();
        t_abort();
        t_slow_tick();
        t_falling();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) chk(1'b0, "watchdog", cyc, 20000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule